// File: doc/BRIEF.md
# Serial Port FIFO Control and Threshold Logic

This block holds the receive and transmit byte queues of an asynchronous serial port, together with the control register that governs them. The receive shift register pushes bytes in, and the host reads them out. The host writes bytes in, and the transmit shift register pulls them out. Framing, baud generation and line status are handled elsewhere. Only the push side of the receive queue and the pop side of the transmit queue face the shift registers.

The host configures the block through a single 8-bit control register. One write can do any of the following:
- turn queueing on or off;
- empty either queue;
- choose how the two active-low DMA ready pins behave;
- select how many received bytes raise the receive-threshold interrupt.

The flush bits clear themselves. Reserved bits are dropped. When queueing is off, each direction acts as a single-byte holding register.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After a synchronous reset: both levels are 0, `rx_overrun` is 0, `rx_trig_irq` is 0, `ctl_rdata` is 0, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R2: Each queue holds up to 16 bytes and pops them in push order. The popped byte appears on `*_pop_data` the cycle after the pop. A pop from an empty queue leaves the level and `*_pop_data` unchanged. A push and a pop in the same cycle are both accepted when the queue is neither full nor empty.
- R3: A push into a full queue is dropped. On the receive side it also sets `rx_overrun`, which stays set until the receive queue is flushed.
- R4: A control write with bit 1 set empties the receive queue and clears `rx_overrun`. This flush takes priority over a receive push or pop in the same cycle, and it leaves `rx_pop_data` unchanged.
- R5: A control write with bit 2 set empties the transmit queue. This flush takes priority over a transmit push or pop in the same cycle.
- R6: `ctl_rdata` returns the stored control value: bit 0 is queue enable, bit 3 is DMA mode, and bits 7:6 are the threshold code. Bits 1, 2, 4 and 5 always read 0.
- R7: Threshold codes 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes. While queueing is off, the threshold is 1. `rx_trig_irq` is 1 exactly while the receive level is at or above the threshold.
- R8: Mode 0 applies whenever bit 0 or bit 3 is 0. In mode 0, `rxrdy_n` is 0 while the receive level is non-zero, and `txrdy_n` is 0 while the transmit level is zero.
- R9: Mode 1 applies when bits 0 and 3 are both 1. In mode 1:
  - `rxrdy_n` falls when the receive level reaches the threshold and rises when the level returns to 0.
  - `txrdy_n` falls when the transmit level is 0 and rises when the transmit queue is full.
- R10: A control write that changes bit 0 empties both queues. While bit 0 is 0, each queue holds at most one byte.
- R11: All outputs are registered. They reflect the state after the clock edge that sampled the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| rx_push | input | 1 | Receive shift register delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | 8 | Last byte read from the receive queue |
| rx_level | output | 5 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky dropped-receive-byte flag |
| tx_push | input | 1 | Host writes a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmit shift register takes a byte |
| tx_pop_data | output | 8 | Last byte taken from the transmit queue |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_trig_irq | output | 1 | Receive threshold interrupt |
| rxrdy_n | output | 1 | Receive DMA ready, active low |
| txrdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
The bench targets four corner cases.

1. A flush written in the same cycle as a push or pop. A design that let the push land would leave one stale byte behind after the flush.
2. The seventeenth receive byte. A design that wrapped its pointer instead of dropping the byte would corrupt the oldest entry and would fail to raise the overrun flag.
3. The mode 1 ready pins, which hold their state between the threshold and empty (or between full and empty). A design that decoded them from the level alone would release `rxrdy_n` as soon as the level fell below the threshold.
4. Toggling the enable bit. A design that forgot to flush, or kept the 16-byte capacity, would accept a second byte in holding-register mode.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic logic [7:0] trig_bytes(trig_sel_e sel);
    case (sel)
      TRIG_1:  return 8'd1;
      TRIG_4:  return 8'd4;
      TRIG_8:  return 8'd8;
      default: return 8'd14;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           single,
  input  logic                           push,
  input  logic [DW-1:0]                  push_data,
  input  logic                           pop,
  output logic [DW-1:0]                  pop_data,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic [$clog2(DEPTH+1)-1:0]     count_nxt,
  output logic                           drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;

  always_comb begin
    count_nxt = count;
    if (flush)
      count_nxt = '0;
    else if (push_ok && !pop_ok)
      count_nxt = count + CW'(1);
    else if (pop_ok && !push_ok)
      count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (pop_ok) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
    end
  end

  // R2: occupancy never exceeds the queue depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4/R5: a flush leaves the queue empty on the next cycle
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));

  // R3: a refused push with no pop leaves the level alone
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       en,
  output logic       dma,
  output trig_sel_e  thr,
  output logic       en_nxt,
  output logic       dma_nxt,
  output trig_sel_e  thr_nxt,
  output logic       flush_rx,
  output logic       flush_tx,
  output logic [7:0] rdata
);
  logic en_flip;

  assign en_flip  = wr & (wdata[0] ^ en);
  assign flush_rx = (wr & wdata[1]) | en_flip;
  assign flush_tx = (wr & wdata[2]) | en_flip;
  assign en_nxt   = wr ? wdata[0] : en;
  assign dma_nxt  = wr ? wdata[3] : dma;
  assign thr_nxt  = wr ? trig_sel_e'(wdata[7:6]) : thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      dma <= 1'b0;
      thr <= TRIG_1;
    end else begin
      en  <= en_nxt;
      dma <= dma_nxt;
      thr <= thr_nxt;
    end
  end

  assign rdata = {thr, 2'b00, dma, 2'b00, en};

  // R6: a write is reflected in the readback on the next cycle
  a_r6_readback: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rdata[0] == $past(wdata[0]) && rdata[3] == $past(wdata[3])
            && rdata[7:6] == $past(wdata[7:6])));
endmodule

// File: rtl/dma_ready.sv
module dma_ready
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(DEPTH+1)-1:0]  rx_nxt,
  input  logic [$clog2(DEPTH+1)-1:0]  tx_nxt,
  input  logic                        en_nxt,
  input  logic                        dma_nxt,
  input  trig_sel_e                   thr_nxt,
  output logic                        irq,
  output logic                        rxrdy_n,
  output logic                        txrdy_n
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] thr_cnt, cap_cnt;
  logic          rx_hold, tx_hold, rx_hold_d, tx_hold_d, mode1;
  logic [7:0]    tb;

  assign tb      = trig_bytes(thr_nxt);
  assign thr_cnt = en_nxt ? tb[CW-1:0] : CW'(1);
  assign cap_cnt = en_nxt ? CW'(DEPTH) : CW'(1);
  assign mode1   = en_nxt & dma_nxt;

  always_comb begin
    rx_hold_d = rx_hold;
    if (rx_nxt == '0)          rx_hold_d = 1'b0;
    else if (rx_nxt >= thr_cnt) rx_hold_d = 1'b1;
    tx_hold_d = tx_hold;
    if (tx_nxt == '0)           tx_hold_d = 1'b1;
    else if (tx_nxt >= cap_cnt) tx_hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= 1'b0;
      tx_hold <= 1'b1;
      irq     <= 1'b0;
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b0;
    end else begin
      rx_hold <= rx_hold_d;
      tx_hold <= tx_hold_d;
      irq     <= (rx_nxt >= thr_cnt);
      rxrdy_n <= mode1 ? ~rx_hold_d : (rx_nxt == '0);
      txrdy_n <= mode1 ? ~tx_hold_d : (tx_nxt != '0);
    end
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ctl_wr,
  input  logic [7:0]                  ctl_wdata,
  output logic [7:0]                  ctl_rdata,
  input  logic                        rx_push,
  input  logic [DW-1:0]               rx_push_data,
  input  logic                        rx_pop,
  output logic [DW-1:0]               rx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0]  rx_level,
  output logic                        rx_overrun,
  input  logic                        tx_push,
  input  logic [DW-1:0]               tx_push_data,
  input  logic                        tx_pop,
  output logic [DW-1:0]               tx_pop_data,
  output logic [$clog2(DEPTH+1)-1:0]  tx_level,
  output logic                        rx_trig_irq,
  output logic                        rxrdy_n,
  output logic                        txrdy_n
);
  localparam int CW = $clog2(DEPTH+1);

  logic          en, dma, en_nxt, dma_nxt, flush_rx, flush_tx;
  trig_sel_e     thr, thr_nxt;
  logic [CW-1:0] rx_nxt, tx_nxt;
  logic          rx_drop, tx_drop;

  fifo_ctl_reg u_ctl (
    .clk, .rst, .wr(ctl_wr), .wdata(ctl_wdata),
    .en, .dma, .thr, .en_nxt, .dma_nxt, .thr_nxt,
    .flush_rx, .flush_tx, .rdata(ctl_rdata)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk, .rst, .flush(flush_rx), .single(~en),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
    .pop_data(rx_pop_data), .count(rx_level), .count_nxt(rx_nxt),
    .drop(rx_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk, .rst, .flush(flush_tx), .single(~en),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
    .pop_data(tx_pop_data), .count(tx_level), .count_nxt(tx_nxt),
    .drop(tx_drop)
  );

  dma_ready #(.DEPTH(DEPTH)) u_rdy (
    .clk, .rst, .rx_nxt, .tx_nxt, .en_nxt, .dma_nxt, .thr_nxt,
    .irq(rx_trig_irq), .rxrdy_n, .txrdy_n
  );

  always_ff @(posedge clk) begin
    if (rst || flush_rx) rx_overrun <= 1'b0;
    else if (rx_drop)    rx_overrun <= 1'b1;
  end

  logic [7:0] thr_b;
  assign thr_b = trig_bytes(thr);

  // R7: interrupt tracks level against the selected threshold
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    rx_trig_irq == (rx_level >= (en ? thr_b[CW-1:0] : CW'(1))));

  // R8: mode 0 receive pin follows non-empty
  a_r8_mode0_rx: assert property (@(posedge clk) disable iff (rst)
    !(en && dma) |-> (rxrdy_n == (rx_level == '0)));

  // R9: mode 1 transmit pin is inactive when the queue is full
  a_r9_mode1_tx_full: assert property (@(posedge clk) disable iff (rst)
    (en && dma && tx_level == CW'(DEPTH)) |-> txrdy_n);

  // R10: with queueing off each side holds at most one byte
  a_r10_single_byte: assert property (@(posedge clk) disable iff (rst)
    !en |-> (rx_level <= CW'(1) && tx_level <= CW'(1)));

  // R3: a dropped receive byte raises the overrun flag
  a_r3_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_drop && !flush_rx) |=> rx_overrun);
endmodule

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;
  logic       clk = 0, rst = 1;
  logic       ctl_wr = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_push_data = 0, tx_push_data = 0, rx_pop_data, tx_pop_data;
  logic [4:0] rx_level, tx_level;
  logic       rx_overrun, rx_trig_irq, rxrdy_n, txrdy_n;

  always #2.5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] rxq[$], txq[$];
  bit m_en, m_dma, m_ovr, m_rh, m_th, m_irq, m_rxn, m_txn;
  logic [1:0] m_thr;
  logic [7:0] m_rxd, m_txd;

  function automatic int tbl(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    rxq.delete(); txq.delete();
    m_en = 0; m_dma = 0; m_ovr = 0; m_rh = 0; m_th = 1; m_thr = 0;
    m_irq = 0; m_rxn = 1; m_txn = 0; m_rxd = 0; m_txd = 0;
  endtask

  task automatic model_step(bit wr, logic [7:0] wd, bit rp, logic [7:0] rpd,
                            bit rpop, bit tp, logic [7:0] tpd, bit tpop);
    int cap = m_en ? 16 : 1;
    bit fr = wr && (wd[1] || (wd[0] != m_en));
    bit ft = wr && (wd[2] || (wd[0] != m_en));
    int thr, capn, rn, tn;
    bit mode1;
    if (fr) begin rxq.delete(); m_ovr = 0; end
    else begin
      bit full = rxq.size() >= cap;
      bit emp  = rxq.size() == 0;
      if (rpop && !emp) m_rxd = rxq.pop_front();
      if (rp && !full) rxq.push_back(rpd);
      else if (rp) m_ovr = 1;
    end
    if (ft) txq.delete();
    else begin
      bit full = txq.size() >= cap;
      bit emp  = txq.size() == 0;
      if (tpop && !emp) m_txd = txq.pop_front();
      if (tp && !full) txq.push_back(tpd);
    end
    if (wr) begin m_en = wd[0]; m_dma = wd[3]; m_thr = wd[7:6]; end
    thr  = m_en ? tbl(m_thr) : 1;
    capn = m_en ? 16 : 1;
    rn = rxq.size(); tn = txq.size();
    if (rn == 0) m_rh = 0; else if (rn >= thr) m_rh = 1;
    if (tn == 0) m_th = 1; else if (tn >= capn) m_th = 0;
    m_irq = rn >= thr;
    mode1 = m_en && m_dma;
    m_rxn = mode1 ? !m_rh : (rn == 0);
    m_txn = mode1 ? !m_th : (tn != 0);
  endtask

  task automatic compare_all();
    bit mode1 = m_en && m_dma;
    check("R2", rx_level, rxq.size());
    check("R2", tx_level, txq.size());
    check("R2", rx_pop_data, m_rxd);
    check("R2", tx_pop_data, m_txd);
    check("R3", rx_overrun, m_ovr);
    check("R6", ctl_rdata, {m_thr, 2'b00, m_dma, 2'b00, m_en});
    check("R7", rx_trig_irq, m_irq);
    check(mode1 ? "R9" : "R8", rxrdy_n, m_rxn);
    check(mode1 ? "R9" : "R8", txrdy_n, m_txn);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit wr, logic [7:0] wd, bit rp, logic [7:0] rpd,
                     bit rpop, bit tp, logic [7:0] tpd, bit tpop);
    ctl_wr = wr; ctl_wdata = wd; rx_push = rp; rx_push_data = rpd; rx_pop = rpop;
    tx_push = tp; tx_push_data = tpd; tx_pop = tpop;
    @(posedge clk);
    model_step(wr, wd, rp, rpd, rpop, tp, tpd, tpop);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int phase_rp, phase_rq, phase_tp, phase_tq;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1", rx_level, 0);  check("R1", tx_level, 0);
    check("R1", rxrdy_n, 1);   check("R1", txrdy_n, 0);
    check("R1", rx_trig_irq, 0); check("R1", ctl_rdata, 0);
    check("R1", rx_overrun, 0);

    // enable queues, reserved and flush bits set: flush bits read 0
    cyc(1, 8'h37, 0, 0, 0, 0, 0, 0);
    check("R6", ctl_rdata, 8'h01);
    // R11: one push shows on the pins right after its edge
    cyc(0, 0, 1, 8'hA5, 0, 0, 0, 0);
    check("R11", rxrdy_n, 0);
    check("R11", rx_level, 1);
    // R3: fill to 16, then the 17th push is dropped
    for (int i = 1; i < 17; i++) cyc(0, 0, 1, 8'(i), 0, 0, 0, 0);
    check("R3", rx_level, 16);
    check("R3", rx_overrun, 1);
    // R2: drain, order checked by compare_all, extra pop on empty
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
    check("R2", rx_pop_data, 15);
    check("R2", rx_level, 0);

    // R7/R9: threshold 14, mode 1 (reserved bits dropped)
    cyc(1, 8'hF9, 0, 0, 0, 0, 0, 0);
    check("R6", ctl_rdata, 8'hC9);
    check("R9", txrdy_n, 0);
    for (int i = 0; i < 13; i++) cyc(0, 0, 1, 8'(i), 0, 0, 0, 0);
    check("R7", rx_trig_irq, 0);
    check("R9", rxrdy_n, 1);
    cyc(0, 0, 1, 8'h55, 0, 0, 0, 0);
    check("R7", rx_trig_irq, 1);
    check("R9", rxrdy_n, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    check("R7", rx_trig_irq, 0);
    check("R9", rxrdy_n, 0);

    // R4: flush rx wins over a push in the same cycle
    cyc(1, 8'hCB, 1, 8'h99, 1, 0, 0, 0);
    check("R4", rx_level, 0);
    check("R4", rx_pop_data, 0);
    check("R9", rxrdy_n, 1);

    // R9 tx: fill transmit queue, pin released at full, held until empty
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, 1, 8'(8'h40 + i), 0);
    check("R9", txrdy_n, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    check("R9", txrdy_n, 1);
    // R5: flush tx wins over a push
    cyc(1, 8'hCD, 0, 0, 0, 1, 8'h77, 0);
    check("R5", tx_level, 0);
    check("R9", txrdy_n, 0);

    // R10: disable -> flush and single byte holding
    cyc(0, 0, 1, 8'h11, 0, 1, 8'h22, 0);
    cyc(1, 8'h08, 0, 0, 0, 0, 0, 0);
    check("R10", rx_level, 0);
    check("R10", tx_level, 0);
    cyc(0, 0, 1, 8'h31, 0, 1, 8'h32, 0);
    cyc(0, 0, 1, 8'h33, 0, 1, 8'h34, 0);
    check("R10", rx_level, 1);
    check("R10", tx_level, 1);
    check("R10", rx_overrun, 1);
    check("R8", txrdy_n, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 1);
    check("R10", rx_pop_data, 8'h31);
    check("R10", tx_pop_data, 8'h32);

    // constrained random
    phase_rp = 50; phase_rq = 50; phase_tp = 50; phase_tq = 50;
    for (int n = 0; n < 4000; n++) begin
      bit wr; logic [7:0] wd;
      if (n % 150 == 0) begin
        phase_rp = $urandom_range(90, 10); phase_rq = $urandom_range(90, 10);
        phase_tp = $urandom_range(90, 10); phase_tq = $urandom_range(90, 10);
      end
      wr = ($urandom_range(99, 0) < 3);
      wd = 8'($urandom);
      if ($urandom_range(7, 0) != 0) wd[0] = 1'b1;
      if ($urandom_range(3, 0) != 0) wd[1] = 1'b0;
      if ($urandom_range(3, 0) != 0) wd[2] = 1'b0;
      cyc(wr, wd,
          $urandom_range(99, 0) < phase_rp, 8'($urandom), $urandom_range(99, 0) < phase_rq,
          $urandom_range(99, 0) < phase_tp, 8'($urandom), $urandom_range(99, 0) < phase_tq);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule